// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or dropped. It watches the byte stream of the frame. The first byte of each frame is flagged by a start marker. The block gathers the six destination address bytes and produces one decision, tagged with a code that says why the frame was accepted or rejected.

Individual (unicast) destinations are accepted when they equal the programmed station address exactly, or when they hit a 64-entry individual hash table. Group destinations are split into two kinds. The all-ones broadcast address is either accepted outright or refused by a broadcast-reject option. Every other group address is multicast and is checked against a 64-entry group hash table. A promiscuous mode forces acceptance of every frame, but the reason code still reports the match that would have applied.

The hash index is built while the bytes arrive. The block runs a CRC over the destination bytes as they stream in, so no wide parallel CRC is needed once the address is complete.

Top module: `eth_dest_filter`

## Requirements
- R1: After reset, `dec_vld`, `dec_accept` and `dec_reason` are all zero.
- R2: Bytes are counted only in cycles where `byte_vld` is high. The first counted byte is the one that carries `byte_sof`. If the sixth counted byte is sampled at clock edge E, `dec_vld` is high for exactly the one cycle after edge E+1, and the decision fields are valid in that cycle.
- R3: The first byte on the wire is address bits [47:40], and its bit 0 (address bit 40) is the group bit. A destination with the group bit clear that equals `cfg_station` is accepted with reason 1 (exact). The exact match takes priority over the individual hash.
- R4: A destination with the group bit clear that does not equal `cfg_station` is accepted with reason 2 (individual hash) when bit `idx` of `cfg_ind_tbl` is set.
- R5: A destination with the group bit set that is not all-ones is accepted with reason 3 (multicast hash) when bit `idx` of `cfg_grp_tbl` is set.
- R6: With `cfg_bc_reject` low, the all-ones destination is accepted with reason 4, whatever the contents of the hash tables.
- R7: With `cfg_bc_reject` high, the all-ones destination gets reason 5 and is rejected unless promiscuous mode is on.
- R8: Any destination not covered by R3 to R7 gets reason 0 and is rejected.
- R9: With `cfg_promisc` high, `dec_accept` is 1 for every frame, and `dec_reason` carries the same code it would carry with promiscuous mode off.
- R10: `idx` is bits [31:26] of a 32-bit CRC register. The register is preset to all-ones and is shifted left once per destination bit, with the polynomial 0x04C11DB7. The bits go in byte order, and within each byte least significant bit first. The feedback bit is register bit 31 XOR the data bit. No final inversion is applied.
- R11: Bytes that arrive before any start marker, or after the sixth destination byte, never produce a strobe. A new start marker during address collection drops the partial address and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | A frame byte is present this cycle |
| byte_sof | input | 1 | Present byte is the first byte of a frame |
| byte_dat | input | 8 | Frame byte |
| cfg_station | input | 48 | Station address, bits [47:40] first on the wire |
| cfg_ind_tbl | input | 64 | Individual address hash table |
| cfg_grp_tbl | input | 64 | Multicast hash table |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bc_reject | input | 1 | Refuse broadcast frames |
| dec_vld | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_reason | output | 3 | 0 none, 1 exact, 2 individual hash, 3 multicast hash, 4 broadcast, 5 broadcast refused |

## Verification
The hardest case to reach from the ports is an individual hash hit, because it needs a unicast address that misses the exact compare but lands on a set table bit. Reaching the exact-match priority over a hash hit on the same frame is just as hard. The bench computes each address's hash index itself. Directed frames then set only that one table bit, or set every bit alongside an exact match. Random frames with half-full tables, with random gaps between bytes and trailing payload, cover the other paths and the one-strobe timing.

// File: rtl/eth_dest_filter_pkg.sv
package eth_dest_filter_pkg;

    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_EXACT  = 3'd1,
        RSN_IHASH  = 3'd2,
        RSN_GHASH  = 3'd3,
        RSN_BCAST  = 3'd4,
        RSN_BC_REJ = 3'd5
    } reason_e;

    // Advance the CRC by one byte, least significant data bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/edf_collect.sv
module edf_collect
    import eth_dest_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_vld_i,
    input  logic                    byte_sof_i,
    input  logic [7:0]              byte_dat_i,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic [CRC_W-1:0]        crc_o,
    output logic                    done_o
);
    localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
    localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
        logic              done;
    } col_t;

    col_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (byte_vld_i && byte_sof_i) begin
            st_d.cnt  = CNT_W'(1);
            st_d.addr = {{(ADDR_W-8){1'b0}}, byte_dat_i};
            st_d.crc  = crc_step_byte(CRC_SEED, byte_dat_i);
            st_d.done = (ADDR_BYTES == 1);
        end else if (byte_vld_i && (st_q.cnt != '0) && (st_q.cnt < CNT_FULL)) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.addr = {st_q.addr[ADDR_W-9:0], byte_dat_i};
            st_d.crc  = crc_step_byte(st_q.crc, byte_dat_i);
            st_d.done = (st_q.cnt + CNT_W'(1)) == CNT_FULL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, addr: '0, crc: CRC_SEED, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign crc_o  = st_q.crc;
    assign done_o = st_q.done;

    // R2: a completed address always follows an accepted byte
    p_done_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(byte_vld_i));

    // R11: the byte count never runs past the address length
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

endmodule

// File: rtl/edf_hash_lookup.sv
module edf_hash_lookup #(
    parameter int unsigned HASH_BITS = 6
) (
    input  logic [HASH_BITS-1:0]      idx_i,
    input  logic [(1<<HASH_BITS)-1:0] ind_tbl_i,
    input  logic [(1<<HASH_BITS)-1:0] grp_tbl_i,
    output logic                      ind_hit_o,
    output logic                      grp_hit_o
);
    always_comb begin
        ind_hit_o = ind_tbl_i[idx_i];
        grp_hit_o = grp_tbl_i[idx_i];
    end
endmodule

// File: rtl/edf_decide.sv
module edf_decide
    import eth_dest_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [8*ADDR_BYTES-1:0] station_i,
    input  logic                    ind_hit_i,
    input  logic                    grp_hit_i,
    input  logic                    promisc_i,
    input  logic                    bc_reject_i,
    output logic                    vld_o,
    output logic                    accept_o,
    output logic [2:0]              reason_o
);
    localparam int unsigned ADDR_W  = 8 * ADDR_BYTES;
    localparam int unsigned GRP_POS = ADDR_W - 8;

    typedef struct packed {
        logic    vld;
        logic    accept;
        reason_e reason;
    } dec_t;

    dec_t st_d, st_q;

    logic [ADDR_BYTES-1:0] byte_eq;
    logic                  exact, is_grp, is_bc;
    reason_e               rsn;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_cmp
        assign byte_eq[g] = addr_i[8*g +: 8] == station_i[8*g +: 8];
    end

    always_comb begin
        exact  = &byte_eq;
        is_grp = addr_i[GRP_POS];
        is_bc  = &addr_i;
        if (is_bc) begin
            rsn = bc_reject_i ? RSN_BC_REJ : RSN_BCAST;
        end else if (is_grp) begin
            rsn = grp_hit_i ? RSN_GHASH : RSN_NONE;
        end else if (exact) begin
            rsn = RSN_EXACT;
        end else begin
            rsn = ind_hit_i ? RSN_IHASH : RSN_NONE;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = done_i;
        if (done_i) begin
            st_d.reason = rsn;
            st_d.accept = promisc_i || !((rsn == RSN_NONE) || (rsn == RSN_BC_REJ));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, accept: 1'b0, reason: RSN_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o    = st_q.vld;
    assign accept_o = st_q.accept;
    assign reason_o = st_q.reason;

    // R2: the strobe is a single cycle
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

    // R8: a rejection only carries the no-match or refused-broadcast code
    p_reject_reason_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !st_q.accept) |-> (st_q.reason == RSN_NONE || st_q.reason == RSN_BC_REJ));

    // R9: promiscuous mode at decision time forces acceptance
    p_promisc_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(promisc_i)) |-> st_q.accept);

    // R6: the plain broadcast code only appears with reject off
    p_bcast_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.reason == RSN_BCAST) |-> !$past(bc_reject_i));

endmodule

// File: rtl/eth_dest_filter.sv
module eth_dest_filter
    import eth_dest_filter_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_vld,
    input  logic                      byte_sof,
    input  logic [7:0]                byte_dat,
    input  logic [8*ADDR_BYTES-1:0]   cfg_station,
    input  logic [(1<<HASH_BITS)-1:0] cfg_ind_tbl,
    input  logic [(1<<HASH_BITS)-1:0] cfg_grp_tbl,
    input  logic                      cfg_promisc,
    input  logic                      cfg_bc_reject,
    output logic                      dec_vld,
    output logic                      dec_accept,
    output logic [2:0]                dec_reason
);
    localparam int unsigned ADDR_W = 8 * ADDR_BYTES;

    logic [ADDR_W-1:0]    addr;
    logic [CRC_W-1:0]     crc;
    logic                 done;
    logic                 ind_hit, grp_hit;
    logic [HASH_BITS-1:0] idx;

    assign idx = crc[CRC_W-1 -: HASH_BITS];

    edf_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld),
        .byte_sof_i (byte_sof),
        .byte_dat_i (byte_dat),
        .addr_o     (addr),
        .crc_o      (crc),
        .done_o     (done)
    );

    edf_hash_lookup #(.HASH_BITS(HASH_BITS)) u_hash (
        .idx_i     (idx),
        .ind_tbl_i (cfg_ind_tbl),
        .grp_tbl_i (cfg_grp_tbl),
        .ind_hit_o (ind_hit),
        .grp_hit_o (grp_hit)
    );

    edf_decide #(.ADDR_BYTES(ADDR_BYTES)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done),
        .addr_i      (addr),
        .station_i   (cfg_station),
        .ind_hit_i   (ind_hit),
        .grp_hit_i   (grp_hit),
        .promisc_i   (cfg_promisc),
        .bc_reject_i (cfg_bc_reject),
        .vld_o       (dec_vld),
        .accept_o    (dec_accept),
        .reason_o    (dec_reason)
    );

endmodule

// File: tb/eth_dest_filter_tb.sv
`timescale 1ns/1ps
module eth_dest_filter_tb;

    localparam logic [47:0] STATION = 48'h021A_3C44_5566;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0, byte_sof = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic [47:0] cfg_station = STATION;
    logic [63:0] cfg_ind_tbl = '0, cfg_grp_tbl = '0;
    logic        cfg_promisc = 1'b0, cfg_bc_reject = 1'b0;
    logic        dec_vld, dec_accept;
    logic [2:0]  dec_reason;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    eth_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_dat(byte_dat), .cfg_station(cfg_station), .cfg_ind_tbl(cfg_ind_tbl),
        .cfg_grp_tbl(cfg_grp_tbl), .cfg_promisc(cfg_promisc),
        .cfg_bc_reject(cfg_bc_reject), .dec_vld(dec_vld),
        .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R10: bench model of the hash index
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[31] ^ b[i];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [2:0] exp_reason(input logic [47:0] a);
        if (a == BCAST) return cfg_bc_reject ? 3'd5 : 3'd4;
        if (a[40]) return cfg_grp_tbl[hidx(a)] ? 3'd3 : 3'd0;
        if (a == cfg_station) return 3'd1;
        return cfg_ind_tbl[hidx(a)] ? 3'd2 : 3'd0;
    endfunction

    function automatic string rtag(input logic [2:0] r);
        case (r)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Sends one frame; checks the strobe in every cycle and the decision.
    task automatic send_frame(input logic [47:0] a, input int nextra, input int gapmax,
                              input string tag);
        int since = -1;
        int sent = 0;
        int total = 6 + nextra;
        logic [2:0] er = exp_reason(a);
        logic ea = cfg_promisc || !(er == 3'd0 || er == 3'd5);
        string t = (tag != "") ? tag : (cfg_promisc ? "R9" : rtag(er));
        while (sent < total || since < 3) begin
            @(negedge clk);
            if (since >= 0) since++;
            if (since == 2) begin
                chk("R2 strobe", dec_vld, 1);
                chk({t, " reason"}, dec_reason, er);
                chk({t, " accept"}, dec_accept, ea);
            end else begin
                chk("R11 no strobe", dec_vld, 0);
            end
            if (sent < total && $urandom_range(0, gapmax) == 0) begin
                byte_vld = 1'b1;
                byte_sof = (sent == 0);
                byte_dat = (sent < 6) ? a[47-8*sent -: 8] : 8'($urandom);
                if (sent == 5) since = 0;
                sent++;
            end else begin
                byte_vld = 1'b0;
                byte_sof = 1'b0;
            end
        end
        byte_vld = 1'b0;
        byte_sof = 1'b0;
    endtask

    // Drives bytes that must never complete an address.
    task automatic send_bytes(input int n, input bit first_sof);
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            chk("R11 no strobe", dec_vld, 0);
            byte_vld = (i < n);
            byte_sof = first_sof && (i == 0);
            byte_dat = 8'($urandom);
        end
    endtask

    function automatic logic [47:0] rand_addr(input int kind);
        logic [47:0] a = {16'($urandom), 32'($urandom)};
        case (kind)
            0: return cfg_station;
            1: return BCAST;
            2: begin a[40] = 1'b1; if (a == BCAST) a[0] = 1'b0; return a; end
            default: begin a[40] = 1'b0; return a; end
        endcase
    endfunction

    initial begin
        logic [47:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 vld", dec_vld, 0);
        chk("R1 accept", dec_accept, 0);
        chk("R1 reason", dec_reason, 0);
        rst_n = 1'b1;

        // R11: bytes with no start marker
        send_bytes(9, 1'b0);
        // R11: restart mid-address, then a full frame gives one decision
        send_bytes(4, 1'b1);
        send_frame(STATION, 0, 0, "R11");

        // R3: exact match wins over a full individual table
        cfg_ind_tbl = '1;
        send_frame(STATION, 2, 1, "R3");
        // R4 / R10: unicast miss hitting exactly its own table bit
        a = 48'h0A00_1122_3344;
        cfg_ind_tbl = 64'd1 << hidx(a);
        send_frame(a, 0, 0, "R10");
        cfg_ind_tbl = ~(64'd1 << hidx(a));
        send_frame(a, 0, 0, "R8");
        // R5 / R10: multicast on its own bit only
        a = 48'h0100_5E00_00FB;
        cfg_grp_tbl = 64'd1 << hidx(a);
        send_frame(a, 1, 0, "R10");
        // R6: broadcast with empty tables and reject off
        cfg_ind_tbl = '0; cfg_grp_tbl = '0;
        send_frame(BCAST, 0, 2, "R6");
        // R7: broadcast refused, then accepted in promiscuous mode
        cfg_bc_reject = 1'b1;
        send_frame(BCAST, 0, 0, "R7");
        cfg_promisc = 1'b1;
        send_frame(BCAST, 0, 0, "R9");
        // R9: no-match frame still accepted, reason stays none
        send_frame(48'h0A00_0000_0001, 0, 0, "R9");
        cfg_promisc = 1'b0; cfg_bc_reject = 1'b0;

        // Random frames across every address class and mode
        for (int n = 0; n < 300; n++) begin
            cfg_ind_tbl   = {$urandom, $urandom};
            cfg_grp_tbl   = {$urandom, $urandom};
            cfg_promisc   = ($urandom_range(0, 3) == 0);
            cfg_bc_reject = $urandom_range(0, 1);
            send_frame(rand_addr($urandom_range(0, 3)), $urandom_range(0, 4),
                       $urandom_range(0, 2), "");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule